// File: doc/BRIEF.md
# Double-Pumped Monochrome Pixel Shifter

This block turns frame-buffer words into the serial pixel stream of a 512 x 342 one-bit-per-pixel bitmap display. Memory supplies two 16-bit words in every eight-cycle bus window of the CPU clock. The first word arrives in the fifth CPU cycle of the window and the second in the seventh. The spacing is uneven: 8 pixel times separate the first load from the second, and 24 separate the second from the next first load. Pixels must still leave at a steady rate, so each kind of load writes its word into its own section of a 32-bit shift register. The section is measured from where the shifting has reached at that moment.

The surrounding video timing logic supplies a pixel-tick enable, the pixel slot within the window, the read data, one strobe per load kind and an active-video flag. Pixels leave most significant bit first, one per pixel tick, four per CPU cycle, so one window carries 32 pixels and consumes exactly the two words fetched in it. The block does not generate addresses or sync.

Top module: `dpump_shifter`

## Requirements
- R1: While reset is asserted and after it is released, `pix_out` is 0, and the shift register holds no data: with no loads accepted, every pixel is 0.
- R2: The shift register advances and `pix_out` updates only on clock edges where `pix_en` is 1. With `pix_en` at 0, `pix_out` holds and strobes have no effect.
- R3: The first-word load is taken when `stb_hi` and `pix_en` are both 1 and `slot` equals 16 (`slot` counts pixel ticks 0 to 31 in the window; CPU cycle = slot/4, and the fifth cycle starts at slot 16). The most significant bit of `rd_word` appears on `pix_out` after that same edge.
- R4: The second-word load is taken when `stb_lo` and `pix_en` are both 1 and `slot` equals 24 (start of the seventh CPU cycle). Its word lands 8 bits below the top of the shift register, so its first pixel follows directly after the last bit of the first word.
- R5: With both loads at their slots in every window, consecutive words come out MSB first with no gap or repeated bit. A full 512-pixel line of 32 words is reproduced bit for bit.
- R6: A strobe at any other slot is ignored. No data it carries ever reaches `pix_out`.
- R7: On a pixel tick with `video_on` at 0, `pix_out` is 0. The shift register still advances, so the bits of that tick are discarded rather than delayed.
- R8: When no loads occur, the register drains and `pix_out` becomes 0 once the queued bits are used up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel-tick enable, one pixel per asserted cycle |
| slot | input | 5 | Pixel slot within the 32-pixel bus window |
| rd_word | input | 16 | Frame-buffer read data |
| stb_hi | input | 1 | Load strobe for the fifth-cycle word |
| stb_lo | input | 1 | Load strobe for the seventh-cycle word |
| video_on | input | 1 | Active-video flag |
| pix_out | output | 1 | Serial pixel, 1 = white |

## Verification
On every cycle, the assertions check three things: where each accepted word sits in the register one edge after its load, that the output holds between pixel ticks, and that blanking forces black. They also check that a first-word load drives its MSB out at once. Only the bench scenarios can show that stray strobes leave no trace and that the two uneven loads join into a gap-free stream across window boundaries. The same holds for a 512-bit line coming out in order and for data being discarded during blanking. For these, the bench compares the output against its own queue model of the stream.

// File: rtl/dps_pkg.sv
`timescale 1ns/1ps
package dps_pkg;
  // Kind of frame-buffer load accepted on a pixel tick.
  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_HI   = 2'd1,
    LD_LO   = 2'd2
  } load_e;

  // Default geometry of the bus window.
  localparam int DEF_WORD_W      = 16;
  localparam int DEF_WIN_CYC     = 8;
  localparam int DEF_PIX_PER_CYC = 4;
  localparam int DEF_HI_CYC      = 4;  // fifth cycle, counted from 0
  localparam int DEF_LO_CYC      = 6;  // seventh cycle, counted from 0

  // Bit offset, from the top of the register, at which a word loaded
  // `gap` ticks after the previous word must land for a seamless stream.
  function automatic int lane_offset(input int word_w, input int gap);
    return word_w - gap;
  endfunction
endpackage

// File: rtl/dps_load_decode.sv
`timescale 1ns/1ps
module dps_load_decode
  import dps_pkg::*;
#(
  parameter int SLOT_W  = 5,
  parameter int HI_SLOT = 16,
  parameter int LO_SLOT = 24
) (
  input  logic              pix_en,
  input  logic [SLOT_W-1:0] slot,
  input  logic              stb_hi,
  input  logic              stb_lo,
  output load_e             kind
);
  logic at_hi, at_lo;

  assign at_hi = (slot == SLOT_W'(HI_SLOT));
  assign at_lo = (slot == SLOT_W'(LO_SLOT));

  always_comb begin
    kind = LD_NONE;
    if (pix_en) begin
      if (stb_hi && at_hi)      kind = LD_HI;
      else if (stb_lo && at_lo) kind = LD_LO;
    end
  end
endmodule

// File: rtl/dps_queue.sv
`timescale 1ns/1ps
module dps_queue
  import dps_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LO_OFS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  load_e             kind,
  input  logic [WORD_W-1:0] rd_word,
  output logic              head_bit
);
  localparam int QW = 2 * WORD_W;

  logic [QW-1:0] shreg;
  logic [QW-1:0] merged;

  function automatic logic [QW-1:0] lane_mask(input int ofs);
    return {{WORD_W{1'b1}}, {WORD_W{1'b0}}} >> ofs;
  endfunction

  function automatic logic [QW-1:0] lane_place(input logic [WORD_W-1:0] w, input int ofs);
    return {w, {WORD_W{1'b0}}} >> ofs;
  endfunction

  // Insert the word into the lane that matches its load kind; a load and
  // the shift of the same tick act on the merged value, so no bit is lost.
  always_comb begin
    unique case (kind)
      LD_HI:   merged = (shreg & ~lane_mask(0))      | lane_place(rd_word, 0);
      LD_LO:   merged = (shreg & ~lane_mask(LO_OFS)) | lane_place(rd_word, LO_OFS);
      default: merged = shreg;
    endcase
  end

  assign head_bit = merged[QW-1];

  always_ff @(posedge clk) begin
    if (!rst_n)      shreg <= '0;
    else if (pix_en) shreg <= {merged[QW-2:0], 1'b0};
  end

  // R3: after a first-word load, its lower bits sit at the top of the register
  p_hi_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && kind == LD_HI) |=> shreg[QW-1 -: WORD_W-1] == $past(rd_word[WORD_W-2:0]));

  // R4: after a second-word load, the word sits LO_OFS bits below the top
  p_lo_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && kind == LD_LO) |=> shreg[QW-LO_OFS -: WORD_W] == $past(rd_word));

  // R2: the register never moves without a pixel tick
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(shreg));
endmodule

// File: rtl/dps_blank_gate.sv
`timescale 1ns/1ps
module dps_blank_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_en,
  input  logic video_on,
  input  logic head_bit,
  output logic pix_out
);
  always_ff @(posedge clk) begin
    if (!rst_n)      pix_out <= 1'b0;
    else if (pix_en) pix_out <= video_on & head_bit;
  end

  // R7: a blanked tick shows black
  p_blank_black_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !video_on) |=> !pix_out);

  // R2: output holds between pixel ticks
  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(pix_out));
endmodule

// File: rtl/dpump_shifter.sv
`timescale 1ns/1ps
module dpump_shifter
  import dps_pkg::*;
#(
  parameter int WORD_W      = DEF_WORD_W,
  parameter int WIN_CYC     = DEF_WIN_CYC,
  parameter int PIX_PER_CYC = DEF_PIX_PER_CYC,
  parameter int HI_CYC      = DEF_HI_CYC,
  parameter int LO_CYC      = DEF_LO_CYC,
  localparam int WIN_PIX    = WIN_CYC * PIX_PER_CYC,
  localparam int SLOT_W     = $clog2(WIN_PIX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic [SLOT_W-1:0] slot,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              stb_hi,
  input  logic              stb_lo,
  input  logic              video_on,
  output logic              pix_out
);
  localparam int HI_SLOT = HI_CYC * PIX_PER_CYC;
  localparam int LO_SLOT = LO_CYC * PIX_PER_CYC;
  localparam int GAP     = LO_SLOT - HI_SLOT;
  localparam int LO_OFS  = lane_offset(WORD_W, GAP);

  load_e kind;
  logic  head_bit;

  dps_load_decode #(
    .SLOT_W (SLOT_W),
    .HI_SLOT(HI_SLOT),
    .LO_SLOT(LO_SLOT)
  ) u_decode (
    .pix_en(pix_en),
    .slot  (slot),
    .stb_hi(stb_hi),
    .stb_lo(stb_lo),
    .kind  (kind)
  );

  dps_queue #(
    .WORD_W(WORD_W),
    .LO_OFS(LO_OFS)
  ) u_queue (
    .clk     (clk),
    .rst_n   (rst_n),
    .pix_en  (pix_en),
    .kind    (kind),
    .rd_word (rd_word),
    .head_bit(head_bit)
  );

  dps_blank_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .pix_en  (pix_en),
    .video_on(video_on),
    .head_bit(head_bit),
    .pix_out (pix_out)
  );

  // R3: a first-word load during active video shows its MSB at once
  p_hi_first_pixel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == LD_HI && video_on) |=> pix_out == $past(rd_word[WORD_W-1]));
endmodule

// File: tb/test_dpump_shifter.sv
`timescale 1ns/1ps
module test_dpump_shifter;
  localparam int WIN_PIX = 32;
  localparam int HI_S    = 16;
  localparam int LO_S    = 24;
  localparam int QSZ     = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pix_en;
  logic [4:0]  slot;
  logic [15:0] rd_word;
  logic        stb_hi, stb_lo, video_on;
  logic        pix_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench reference queue of pending pixels
  bit q_bits [QSZ];
  int wr_i = 0;
  int rd_i = 0;

  bit [31:0] win_got, win_exp;
  bit        line_bits [512];
  int        rec_idx = -1;
  int        hold_err;

  always #10 clk = ~clk;

  dpump_shifter i_dpump_shifter (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .slot(slot), .rd_word(rd_word),
    .stb_hi(stb_hi), .stb_lo(stb_lo), .video_on(video_on), .pix_out(pix_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void push_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      q_bits[wr_i % QSZ] = w[i];
      wr_i++;
    end
  endfunction

  function automatic bit pop_bit();
    bit b = 1'b0;
    if (wr_i > rd_i) begin
      b = q_bits[rd_i % QSZ];
      rd_i++;
    end
    return b;
  endfunction

  // mode 0: regular loads, 1: stray strobes only, 3: no strobes
  task automatic run_window(input logic [15:0] wa, input logic [15:0] wb, input int mode,
                            input bit blank_rand, input bit gaps, input bit start_rec);
    hold_err = 0;
    for (int s = 0; s < WIN_PIX; s++) begin
      if (gaps) begin
        int n = $urandom % 3;
        for (int k = 0; k < n; k++) begin
          logic prev;
          pix_en = 1'b0; slot = 5'(s); stb_hi = 1'b1; stb_lo = 1'b1;
          rd_word = 16'($urandom); video_on = 1'($urandom);
          prev = pix_out;
          @(posedge clk); #1;
          if (pix_out !== prev) hold_err++;
        end
      end
      begin
        logic h, l, v;
        logic [15:0] w;
        bit e;
        if (mode == 0) begin
          h = (s == HI_S); l = (s == LO_S);
        end else if (mode == 1) begin
          h = (s != HI_S && s != LO_S) && ($urandom % 3 == 0);
          l = (s != HI_S && s != LO_S) && ($urandom % 3 == 0);
        end else begin
          h = 1'b0; l = 1'b0;
        end
        w = (s == HI_S) ? wa : (s == LO_S) ? wb : 16'($urandom);
        v = blank_rand ? ($urandom % 4 != 0) : 1'b1;
        pix_en = 1'b1; slot = 5'(s); stb_hi = h; stb_lo = l; rd_word = w; video_on = v;
        @(posedge clk); #1;
        // expected stream: accepted only at slot 16 / 24
        if (h && s == HI_S) push_word(w);
        if (l && s == LO_S) push_word(w);
        e = pop_bit();
        if (!v) e = 1'b0;
        win_got[31-s] = pix_out;
        win_exp[31-s] = e;
        if (start_rec && s == HI_S) rec_idx = 0;
        if (rec_idx >= 0 && rec_idx < 512) begin
          line_bits[rec_idx] = pix_out;
          rec_idx++;
        end
      end
    end
    pix_en = 1'b0; stb_hi = 1'b0; stb_lo = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pix_en = 1'b0; stb_hi = 1'b0; stb_lo = 1'b0;
    slot = '0; rd_word = '0; video_on = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(pix_out === 1'b0, "R1", "pix_out during reset", pix_out, 0);
    rst_n = 1'b1;
    rd_i = wr_i;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] words [32];
    bit [31:0] seed_dummy;
    seed_dummy = $urandom(32'h5EED_1234);

    // R1 / R8: reset state and empty register
    do_reset();
    run_window(16'hFFFF, 16'hFFFF, 3, 0, 0, 0);
    check(win_got == 32'h0, "R1", "output after reset with no loads", win_got, 0);

    // R3 / R4: directed placement
    run_window(16'hA5C3, 16'h0F1E, 0, 0, 0, 0);
    check(win_got[15:0] == 16'hA5C3, "R3", "first word on slots 16..31", win_got[15:0], 16'hA5C3);
    check(win_got[15] == 1'b1, "R3", "MSB right after the load edge", win_got[15], 1);
    run_window(16'h8001, 16'h7FFE, 0, 0, 0, 0);
    check(win_got[31:16] == 16'h0F1E, "R4", "second word follows first seamlessly", win_got[31:16], 16'h0F1E);
    check(win_got == win_exp, "R5", "window stream", win_got, win_exp);
    // R8: drain
    run_window(16'hFFFF, 16'hFFFF, 3, 0, 0, 0);
    check(win_got == {16'h7FFE, 16'h0}, "R8", "drain then black", win_got, {16'h7FFE, 16'h0});
    run_window(16'hFFFF, 16'hFFFF, 3, 0, 0, 0);
    check(win_got == 32'h0, "R8", "empty register is black", win_got, 0);

    // R5: full 512-pixel line
    for (int i = 0; i < 32; i++) words[i] = 16'($urandom);
    for (int wdw = 0; wdw < 16; wdw++) begin
      run_window(words[2*wdw], words[2*wdw+1], 0, 0, 0, wdw == 0);
      check(win_got == win_exp, "R5", "line window", win_got, win_exp);
    end
    run_window(16'h0, 16'h0, 3, 0, 0, 0);
    check(win_got == win_exp, "R5", "line tail", win_got, win_exp);
    begin
      int bad = 0;
      for (int i = 0; i < 512; i++)
        if (line_bits[i] != words[i/16][15 - (i % 16)]) bad++;
      check(bad == 0 && rec_idx == 512, "R5", "512-bit line mismatches", bad, 0);
    end

    // R6: stray strobes ignored
    run_window(16'hFFFF, 16'hFFFF, 3, 0, 0, 0);
    run_window(16'hFFFF, 16'hFFFF, 1, 0, 0, 0);
    check(win_got == 32'h0, "R6", "stray strobes leave output black", win_got, 0);
    run_window(16'hFFFF, 16'hFFFF, 3, 0, 0, 0);
    check(win_got == 32'h0, "R6", "no stray data queued", win_got, 0);

    // R7: blanking discards bits
    for (int k = 0; k < 4; k++) begin
      run_window(16'($urandom), 16'($urandom), 0, 1, 0, 0);
      check(win_got == win_exp, "R7", "blanked window", win_got, win_exp);
    end
    run_window(16'hFFFF, 16'hFFFF, 0, 0, 0, 0);
    video_on = 1'b0; pix_en = 1'b1; slot = 5'd0;
    @(posedge clk); #1;
    check(pix_out === 1'b0, "R7", "blanked tick with data queued", pix_out, 0);
    void'(pop_bit());
    pix_en = 1'b0;
    run_window(16'h0, 16'h0, 3, 0, 0, 0);
    check(win_got == win_exp, "R7", "bits after blank continue in place", win_got, win_exp);

    // R2: random enable gaps with random data
    for (int k = 0; k < 6; k++) begin
      run_window(16'($urandom), 16'($urandom), 0, k[0], 1, 0);
      check(hold_err == 0, "R2", "output changed without pixel tick", hold_err, 0);
      check(win_got == win_exp, "R2", "stream with enable gaps", win_got, win_exp);
    end

    // R1: reset mid-stream clears queued data
    run_window(16'hFFFF, 16'hFFFF, 0, 0, 0, 0);
    do_reset();
    run_window(16'hFFFF, 16'hFFFF, 3, 0, 0, 0);
    check(win_got == 32'h0, "R1", "queue cleared by reset", win_got, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule